// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wakeup

This block gathers up to 40 level-sensitive interrupt request lines and picks one winner per cycle for the processor. Each line has a fixed level (1 to 7) and a fixed priority inside that level. A request takes part only if its level is above the processor's current mask, and level 7 is never masked. The winner's level and its vector number are presented on registered outputs. The vector is a fixed offset plus the source index, so every source has its own vector.

Software can promote up to two sources to the top maskable slot through a small byte-wide register window. A service routine can also read an acknowledge register that returns the vector of the best pending request at or above a chosen level. While the device sleeps with its clocks stopped, a purely combinational path raises a wakeup request to the clock generator whenever an unmasked request appears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source i has level 7-(i mod 7), priority 8-((i div 7) mod 9) and vector 62+i.
- R2: The winner is the request with the highest level, then the highest priority, then the lowest index. Its level appears on irq_level_o and its vector on irq_vec_o on the clock edge after the request is sampled. With no winner both outputs read 0.
- R3: A request qualifies only when its level is greater than mask_i. Level 7 always qualifies.
- R4: Remap entries sit at offset 0x00 (entry A) and 0x01 (entry B): bit 7 is valid and bits 6:0 hold the source index. A remapped source arbitrates at level 6 above every native level-6 source, and entry A outranks entry B. Remapping has no effect on a level-7 source.
- R5: A read of offset 0x08+L (L=0..7) returns the vector of the best pending request whose effective level is at least L. mask_i is ignored for this read.
- R6: An acknowledge read with no qualifying request returns 24.
- R7: wake_o is combinational and equals lp_en_i AND (some request qualifies under R3).
- R8: The window is selected when bus_addr_i[23:6] is all ones. bus_ack_o, with bus_rdata_o, pulses one cycle after bus_sel_i. Accesses outside the window get no response.
- R9: bus_err_o replaces bus_ack_o for a non-byte size (bus_size_i not 0), any offset other than 0x00, 0x01 or 0x08..0x0F, and any write to 0x08..0x0F. An erroring write changes no register.
- R10: Reading a remap entry returns what was last written to it. Both entries reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 40 | Level-sensitive requests, one per source |
| mask_i | input | 3 | Current processor interrupt mask |
| lp_en_i | input | 1 | Low-power enable for the wakeup path |
| wake_o | output | 1 | Combinational wakeup request |
| irq_level_o | output | 3 | Registered level of the winner, 0 if none |
| irq_vec_o | output | 8 | Registered vector of the winner, 0 if none |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write |
| bus_addr_i | input | 24 | Byte address |
| bus_size_i | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with bus_ack_o |
| bus_ack_o | output | 1 | Normal completion |
| bus_err_o | output | 1 | Error completion |

## Verification
The bench builds the block with its defaults: 40 sources, vector offset 62, 24-bit addresses. With this set, every single source can be checked against every mask value and every acknowledge level. Every unordered pair of sources can be checked with remapping off and again with both remap entries active, so each level and priority tie-break, and each case where a remap outranks a native source, is covered.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W  = 3;
  localparam int RANK_W = 4;
  localparam int RMP_W  = 7;
  localparam logic [3:0] RANK_RMP_A = 4'd10;
  localparam logic [3:0] RANK_RMP_B = 4'd9;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [RANK_W-1:0] rank;
  } slot_t;

  function automatic logic [LVL_W-1:0] src_level(int i);
    return LVL_W'(7 - (i % 7));
  endfunction

  function automatic logic [RANK_W-1:0] src_prio(int i);
    return RANK_W'(8 - ((i / 7) % 9));
  endfunction
endpackage

// File: rtl/irqc_slot_map.sv
module irqc_slot_map
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic             rmp_vld_i [2],
  input  logic [RMP_W-1:0] rmp_idx_i [2],
  output slot_t [NUM_SRC-1:0] slot_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [LVL_W-1:0]  NAT_LVL = src_level(i);
    localparam logic [RANK_W-1:0] NAT_PRI = src_prio(i);
    always_comb begin
      slot_o[i].lvl  = NAT_LVL;
      slot_o[i].rank = NAT_PRI;
      if (NAT_LVL != 3'd7) begin
        if (rmp_vld_i[0] && rmp_idx_i[0] == RMP_W'(i)) begin
          slot_o[i].lvl  = 3'd6;
          slot_o[i].rank = RANK_RMP_A;
        end else if (rmp_vld_i[1] && rmp_idx_i[1] == RMP_W'(i)) begin
          slot_o[i].lvl  = 3'd6;
          slot_o[i].rank = RANK_RMP_B;
        end
      end
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  slot_t [NUM_SRC-1:0] slot_i,
  input  logic [3:0]         floor_i,
  output logic               hit_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [IDX_W-1:0]   idx_o
);
  slot_t best;
  always_comb begin
    hit_o = 1'b0;
    best  = '0;
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lower index on equal keys
      if (req_i[i] && {1'b0, slot_i[i].lvl} >= floor_i &&
          (!hit_o || slot_i[i] > best)) begin
        hit_o = 1'b1;
        best  = slot_i[i];
        idx_o = IDX_W'(i);
      end
    end
    lvl_o = best.lvl;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [7:0] SPUR_VEC = 8'd24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [3:0]        ack_floor_o,
  input  logic              ack_hit_i,
  input  logic [7:0]        ack_vec_i,
  output logic              rmp_vld_o [2],
  output logic [RMP_W-1:0]  rmp_idx_o [2]
);
  logic [5:0] off;
  logic in_win, is_rmp, is_ack, bad;
  logic [7:0] rd_val;

  assign off         = addr_i[5:0];
  assign in_win      = &addr_i[ADDR_W-1:6];
  assign is_rmp      = off[5:1] == 5'd0;
  assign is_ack      = off[5:3] == 3'd1;
  assign ack_floor_o = {1'b0, off[2:0]};
  assign bad         = (size_i != 2'd0) || !(is_rmp || is_ack) || (we_i && is_ack);

  always_comb begin
    if (is_rmp) rd_val = {rmp_vld_o[off[0]], rmp_idx_o[off[0]]};
    else        rd_val = ack_hit_i ? ack_vec_i : SPUR_VEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o     <= 1'b0;
      err_o     <= 1'b0;
      rdata_o   <= '0;
      rmp_vld_o <= '{default: 1'b0};
      rmp_idx_o <= '{default: '0};
    end else begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
      if (sel_i && in_win) begin
        if (bad) begin
          err_o <= 1'b1;
        end else begin
          ack_o <= 1'b1;
          if (we_i) begin
            rmp_vld_o[off[0]] <= wdata_i[7];
            rmp_idx_o[off[0]] <= wdata_i[6:0];
          end else begin
            rdata_o <= rd_val;
          end
        end
      end
    end
  end

  AST_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && err_o)); // R9
  AST_RESP_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || err_o) |-> $past(sel_i)); // R8
  AST_NARROW_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && in_win && size_i != 2'd0) |=> err_o); // R9
  AST_ERR_KEEPS_RMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(rmp_idx_o[0]) && $stable(rmp_idx_o[1]))); // R9
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W = 24,
  parameter int VEC_OFFSET = 62,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [2:0]         mask_i,
  input  logic               lp_en_i,
  output logic               wake_o,
  output logic [2:0]         irq_level_o,
  output logic [7:0]         irq_vec_o,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [1:0]         bus_size_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               bus_ack_o,
  output logic               bus_err_o
);
  logic             rmp_vld [2];
  logic [RMP_W-1:0] rmp_idx [2];
  slot_t [NUM_SRC-1:0] slots;

  logic [3:0]       run_floor, ack_floor;
  logic             run_hit, ack_hit;
  logic [LVL_W-1:0] run_lvl, ack_lvl;
  logic [IDX_W-1:0] run_idx, ack_idx;

  // level 7 stays eligible under any mask
  assign run_floor = (mask_i == 3'd7) ? 4'd7 : {1'b0, mask_i} + 4'd1;

  irqc_slot_map #(.NUM_SRC(NUM_SRC)) u_map (
    .rmp_vld_i(rmp_vld), .rmp_idx_i(rmp_idx), .slot_o(slots));

  irqc_arb #(.NUM_SRC(NUM_SRC)) u_run_arb (
    .req_i(irq_req_i), .slot_i(slots), .floor_i(run_floor),
    .hit_o(run_hit), .lvl_o(run_lvl), .idx_o(run_idx));

  irqc_arb #(.NUM_SRC(NUM_SRC)) u_ack_arb (
    .req_i(irq_req_i), .slot_i(slots), .floor_i(ack_floor),
    .hit_o(ack_hit), .lvl_o(ack_lvl), .idx_o(ack_idx));

  irqc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .size_i(bus_size_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .ack_o(bus_ack_o), .err_o(bus_err_o),
    .ack_floor_o(ack_floor), .ack_hit_i(ack_hit),
    .ack_vec_i(8'(VEC_OFFSET) + 8'(ack_idx)),
    .rmp_vld_o(rmp_vld), .rmp_idx_o(rmp_idx));

  assign wake_o = lp_en_i & run_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_level_o <= '0;
      irq_vec_o   <= '0;
    end else begin
      irq_level_o <= run_hit ? run_lvl : 3'd0;
      irq_vec_o   <= run_hit ? 8'(VEC_OFFSET) + 8'(run_idx) : 8'd0;
    end
  end

  AST_LEVEL_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != 3'd0) |-> (irq_level_o > $past(mask_i) || irq_level_o == 3'd7)); // R3
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != 3'd0) |-> (irq_vec_o >= 8'(VEC_OFFSET) &&
                               irq_vec_o < 8'(VEC_OFFSET + NUM_SRC))); // R1
  AST_ACK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit |-> ({1'b0, ack_lvl} >= ack_floor)); // R5
  AST_NO_WAKE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_en_i |-> !wake_o); // R7
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;
  localparam logic [23:0] BASE = 24'hFFFFC0;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [2:0] mask = 0;
  logic lp_en = 0, sel = 0, we = 0;
  logic [23:0] addr = BASE;
  logic [1:0] size = 0;
  logic [7:0] wdata = 0;
  logic wake, ack, err;
  logic [2:0] lvl;
  logic [7:0] vec, rdata;
  int total = 0, bad = 0;
  bit rv0 = 0, rv1 = 0;
  int ri0 = 0, ri1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .mask_i(mask), .lp_en_i(lp_en),
    .wake_o(wake), .irq_level_o(lvl), .irq_vec_o(vec),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_size_i(size),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_ack_o(ack), .bus_err_o(err));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int nat_lvl(int i); return 7 - (i % 7); endfunction
  function automatic int eff_lvl(int i);
    if (nat_lvl(i) != 7 && ((rv0 && ri0 == i) || (rv1 && ri1 == i))) return 6;
    return nat_lvl(i);
  endfunction
  function automatic int eff_rank(int i);
    if (nat_lvl(i) != 7 && rv0 && ri0 == i) return 10;
    if (nat_lvl(i) != 7 && rv1 && ri1 == i) return 9;
    return 8 - ((i / 7) % 9);
  endfunction
  function automatic int winner(logic [N-1:0] r, int flr);
    int w = -1, bk = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && eff_lvl(i) >= flr && eff_lvl(i) * 16 + eff_rank(i) > bk) begin
        bk = eff_lvl(i) * 16 + eff_rank(i);
        w = i;
      end
    return w;
  endfunction
  function automatic int run_floor(int m); return (m == 7) ? 7 : m + 1; endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus(input logic w, input logic [23:0] a, input logic [1:0] sz,
                     input logic [7:0] wd, output logic ak, output logic er,
                     output logic [7:0] rd);
    sel = 1; we = w; addr = a; size = sz; wdata = wd;
    step();
    ak = ack; er = err; rd = rdata;
    sel = 0; we = 0;
  endtask

  task automatic check_run(input string r);
    int w = winner(req, run_floor(int'(mask)));
    int el = (w < 0) ? 0 : eff_lvl(w);
    int ev = (w < 0) ? 0 : 62 + w;
    chk(int'(lvl) == el, r, lvl, el);
    chk(int'(vec) == ev, r, vec, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ak, er;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // reset state
    chk(lvl == 0 && vec == 0, "R2 reset", vec, 0);
    chk(!wake && !ack && !err, "R7 reset", wake, 0);
    bus(0, BASE + 0, 0, 0, ak, er, rd);
    chk(ak && rd == 0, "R10 reset entry A", rd, 0);

    // single sources across all masks, wakeup on and off
    for (int i = 0; i < N; i++)
      for (int m = 0; m < 8; m++) begin
        req = '0; req[i] = 1'b1; mask = 3'(m); lp_en = 1'(m % 2);
        #1;
        chk(wake == (lp_en && (nat_lvl(i) > m || nat_lvl(i) == 7)), "R7 wake", wake, m);
        step();
        check_run("R1 R3 single");
      end

    // all pairs, no remap, mask 0
    mask = 0; lp_en = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        req = '0; req[i] = 1; req[j] = 1;
        step();
        check_run("R2 pair");
      end

    // acknowledge reads by level
    for (int i = 0; i < N; i++)
      for (int l = 0; l < 8; l++) begin
        int ev;
        req = '0; req[i] = 1; mask = 7;
        ev = (nat_lvl(i) >= l) ? 62 + i : 24;
        bus(0, BASE + 24'(8 + l), 0, 0, ak, er, rd);
        chk(ak && !er && int'(rd) == ev, "R5 ack read", rd, ev);
      end
    req = '0;
    bus(0, BASE + 8, 0, 0, ak, er, rd);
    chk(ak && rd == 24, "R6 spurious", rd, 24);

    // remap: A = src 30 (lvl 5), B = src 20 (lvl 1)
    bus(1, BASE + 0, 0, 8'h80 | 8'd30, ak, er, rd);
    bus(1, BASE + 1, 0, 8'h80 | 8'd20, ak, er, rd);
    rv0 = 1; ri0 = 30; rv1 = 1; ri1 = 20;
    bus(0, BASE + 0, 0, 0, ak, er, rd);
    chk(ak && rd == 8'h9E, "R10 readback A", rd, 8'h9E);
    bus(0, BASE + 1, 0, 0, ak, er, rd);
    chk(ak && rd == 8'h94, "R10 readback B", rd, 8'h94);
    mask = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        req = '0; req[i] = 1; req[j] = 1;
        step();
        check_run("R4 pair remap");
      end
    req = '0; req[20] = 1; mask = 5;
    step();
    chk(lvl == 6 && vec == 82, "R4 remapped above mask", vec, 82);
    req = '0; req[20] = 1; req[1] = 1; mask = 0;
    bus(0, BASE + 8 + 6, 0, 0, ak, er, rd);
    chk(rd == 82, "R5 ack sees remap", rd, 82);

    // remap of a level-7 source has no effect
    bus(1, BASE + 0, 0, 8'h80, ak, er, rd);
    rv0 = 1; ri0 = 0;
    req = '0; req[0] = 1; req[7] = 1; mask = 7;
    step();
    chk(lvl == 7 && vec == 62, "R4 level 7 kept", vec, 62);

    // bus errors and window
    bus(0, BASE + 0, 1, 0, ak, er, rd);
    chk(er && !ak, "R9 half size", er, 1);
    bus(0, BASE + 1, 2, 0, ak, er, rd);
    chk(er && !ak, "R9 word size", er, 1);
    bus(0, BASE + 2, 0, 0, ak, er, rd);
    chk(er && !ak, "R9 reserved 0x02", er, 1);
    bus(0, BASE + 24'h10, 0, 0, ak, er, rd);
    chk(er && !ak, "R9 reserved 0x10", er, 1);
    bus(0, BASE + 24'h3F, 0, 0, ak, er, rd);
    chk(er && !ak, "R9 reserved 0x3F", er, 1);
    bus(1, BASE + 24'h0A, 0, 8'h11, ak, er, rd);
    chk(er && !ak, "R9 write to ack", er, 1);
    bus(1, BASE + 1, 1, 8'h05, ak, er, rd);
    chk(er, "R9 bad write err", er, 1);
    bus(0, BASE + 1, 0, 0, ak, er, rd);
    chk(ak && rd == 8'h94, "R9 bad write ignored", rd, 8'h94);
    bus(0, 24'hFFFF00, 0, 0, ak, er, rd);
    chk(!ak && !er, "R8 outside window", ak, 0);
    bus(1, 24'h000001, 0, 8'h00, ak, er, rd);
    chk(!ak && !er, "R8 outside write", ak, 0);
    bus(0, BASE + 1, 0, 0, ak, er, rd);
    chk(ak && rd == 8'h94, "R8 outside write ignored", rd, 8'h94);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule